// File: doc/BRIEF.md
# Fuse Word Read Controller

This block sits between a simple synchronous register bus and a one-time-programmable fuse macro that stores 32 words of 16 bits. Software uses it to fetch one fuse word at a time. The block never programs fuses. The macro is outside the block: the controller drives a word address and a read enable to it and samples the 16-bit word that comes back.

A module-enable input gates all activity. While it is low, the controller is parked: it shows no standby, it ignores every register write, and it forgets any read in progress. Software works in this order:
1. Raise enable.
2. Wait for standby.
3. Write the word index.
4. Strobe a read start.
5. Poll for the read-done flag.
6. Fetch the data word.
7. Strobe clear-done.
8. Drop enable.

The access takes a fixed number of clock cycles. The done flag stays set until software clears it, and any read start that arrives while an access is in flight or a result is pending is discarded.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: While reset is asserted, the status register (offset 0x14), the read-data register (offset 0x04) and the index register (offset 0x0C) all read 0.
- R2: The index register keeps only bits [4:0] of a write. Bits [31:5] read back as 0.
- R3: Status bit 2 is standby. It reads 0 while `mod_en` is low and becomes 1 in the cycle after `mod_en` is first sampled high.
- R4: While `mod_en` is low, every register write is ignored. This covers index writes and all mode strobes.
- R5: A write to offset 0x10 with bit 1 set starts a read, but only while in standby. Standby then drops and status bit 1 (read busy) is 1 for exactly 8 cycles. During that window `fz_rden` is high and `fz_addr` holds the index captured at the start.
- R6: When the access ends, read busy clears and status bit 4 (done) sets. The read-data register returns the addressed fuse word in bits [15:0] and 0 in bits [31:16].
- R7: Done stays set until a write to offset 0x10 with bit 2 set. Standby is 1 again in the cycle after that clear.
- R8: A read start issued while busy, or while done is still set, is ignored. The result and the flags are unchanged by it.
- R9: Status bit 3 is a registered copy of the `prot_i` strap input.
- R10: A write to offset 0x10 with bit 0 set (program start) has no effect. Status bit 0 (program busy) always reads 0.
- R11: Lowering `mod_en` during an access abandons it. Status returns to parked with no busy and no done, and the read-data register keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low parks the controller |
| prot_i | input | 1 | Protection strap, mirrored in status |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| fz_addr | output | 5 | Fuse word address |
| fz_rden | output | 1 | Fuse read enable during an access |
| fz_q | input | 16 | Word returned by the fuse macro |

## Verification
The bench builds the block with its default parameters: 32 words of 16 bits and an 8-cycle access. With these values every fuse index is read back against the preloaded pattern, and the busy window is counted cycle by cycle to its exact length. The 8-cycle window also leaves room to inject a second start and an index change in mid-access, and to drop enable part-way through a read.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_STBY = 2'd1,
        PH_BUSY = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // register byte offsets that software decodes
    localparam int unsigned OFS_RDATA  = 32'h04;
    localparam int unsigned OFS_INDEX  = 32'h0C;
    localparam int unsigned OFS_MODE   = 32'h10;
    localparam int unsigned OFS_STATUS = 32'h14;

    // mode strobe bit positions
    localparam int unsigned MODE_PRG = 0;
    localparam int unsigned MODE_RD  = 1;
    localparam int unsigned MODE_CLR = 2;

    // status bit positions
    localparam int unsigned ST_PBUSY = 0;
    localparam int unsigned ST_RBUSY = 1;
    localparam int unsigned ST_STBY  = 2;
    localparam int unsigned ST_PROT  = 3;
    localparam int unsigned ST_DONE  = 4;

endpackage

// File: rtl/fuse_rd_regif.sv
`timescale 1ns/1ps
module fuse_rd_regif
    import fuse_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              busy_i,
    input  logic              stby_i,
    input  logic              done_i,
    input  logic              prot_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rd_stb,
    output logic              clr_stb,
    output logic [IDX_W-1:0]  idx_o,
    output logic [BUS_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_RDATA  = ADDR_W'(OFS_RDATA);
    localparam logic [ADDR_W-1:0] A_INDEX  = ADDR_W'(OFS_INDEX);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } rif_t;

    rif_t rif_d, rif_q;
    logic wr_ok;
    logic mode_wr;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign wr_ok   = bus_wr & mod_en;
    assign mode_wr = wr_ok && (bus_addr == A_MODE);
    assign rd_stb  = mode_wr && bus_wdata[MODE_RD];
    assign clr_stb = mode_wr && bus_wdata[MODE_CLR];

    always_comb begin
        rif_d = rif_q;
        if (wr_ok && (bus_addr == A_INDEX)) begin
            rif_d.idx = bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rif_q.idx <= '0;
        end else begin
            rif_q <= rif_d;
        end
    end

    assign idx_o = rif_q.idx;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RDATA:  bus_rdata = BUS_W'(word_i);
            A_INDEX:  bus_rdata = BUS_W'(rif_q.idx);
            A_STATUS: begin
                bus_rdata[ST_PBUSY] = 1'b0;
                bus_rdata[ST_RBUSY] = busy_i;
                bus_rdata[ST_STBY]  = stby_i;
                bus_rdata[ST_PROT]  = prot_i;
                bus_rdata[ST_DONE]  = done_i;
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned ACC_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              prot_i,
    input  logic              rd_stb,
    input  logic              clr_stb,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] fz_q,
    output logic [IDX_W-1:0]  fz_addr,
    output logic              fz_rden,
    output logic              busy_o,
    output logic              stby_o,
    output logic              done_o,
    output logic              prot_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned CNT_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  cap;
        logic [WORD_W-1:0] word;
        logic              prot;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.prot = prot_i;
        if (!mod_en) begin
            seq_d.ph = PH_OFF;
        end else begin
            case (seq_q.ph)
                PH_OFF: begin
                    seq_d.ph = PH_STBY;
                end
                PH_STBY: begin
                    if (rd_stb) begin
                        seq_d.ph  = PH_BUSY;
                        seq_d.cnt = '0;
                        seq_d.cap = idx_i;
                    end
                end
                PH_BUSY: begin
                    if (seq_q.cnt == CNT_LAST) begin
                        seq_d.word = fz_q;
                        seq_d.ph   = PH_DONE;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                PH_DONE: begin
                    if (clr_stb) begin
                        seq_d.ph = PH_STBY;
                    end
                end
                default: seq_d.ph = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph   <= PH_OFF;
            seq_q.cnt  <= '0;
            seq_q.cap  <= '0;
            seq_q.word <= '0;
            seq_q.prot <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.ph == PH_BUSY);
    assign stby_o  = (seq_q.ph == PH_STBY);
    assign done_o  = (seq_q.ph == PH_DONE);
    assign prot_o  = seq_q.prot;
    assign word_o  = seq_q.word;
    assign fz_addr = seq_q.cap;
    assign fz_rden = busy_o;

endmodule

// File: rtl/fuse_rd_ctrl.sv
`timescale 1ns/1ps
module fuse_rd_ctrl #(
    parameter int unsigned N_WORDS = 32,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned BUS_W   = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned ACC_CYC = 8,
    localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              prot_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [IDX_W-1:0]  fz_addr,
    output logic              fz_rden,
    input  logic [WORD_W-1:0] fz_q
);

    logic              rd_stb;
    logic              clr_stb;
    logic [IDX_W-1:0]  idx_q;
    logic              s_busy;
    logic              s_stby;
    logic              s_done;
    logic              s_prot;
    logic [WORD_W-1:0] s_word;

    fuse_rd_regif #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy_i    (s_busy),
        .stby_i    (s_stby),
        .done_i    (s_done),
        .prot_i    (s_prot),
        .word_i    (s_word),
        .rd_stb    (rd_stb),
        .clr_stb   (clr_stb),
        .idx_o     (idx_q),
        .bus_rdata (bus_rdata)
    );

    fuse_rd_seq #(
        .IDX_W   (IDX_W),
        .WORD_W  (WORD_W),
        .ACC_CYC (ACC_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mod_en  (mod_en),
        .prot_i  (prot_i),
        .rd_stb  (rd_stb),
        .clr_stb (clr_stb),
        .idx_i   (idx_q),
        .fz_q    (fz_q),
        .fz_addr (fz_addr),
        .fz_rden (fz_rden),
        .busy_o  (s_busy),
        .stby_o  (s_stby),
        .done_o  (s_done),
        .prot_o  (s_prot),
        .word_o  (s_word)
    );

endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic             busy,
    input logic             stby,
    input logic             done,
    input logic             clr_stb,
    input logic [IDX_W-1:0] fz_addr
);

    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, stby, done})); // R5

    AST_NO_STBY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> !stby); // R3

    AST_BUSY_FROM_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stby)); // R5

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mod_en && !clr_stb) |=> done); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fz_addr)); // R5

endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .busy    (s_busy),
    .stby    (s_stby),
    .done    (s_done),
    .clr_stb (clr_stb),
    .fz_addr (fz_addr)
);

// File: tb/fuse_rd_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_tb;

    localparam logic [7:0] A_RDATA  = 8'h04;
    localparam logic [7:0] A_INDEX  = 8'h0C;
    localparam logic [7:0] A_MODE   = 8'h10;
    localparam logic [7:0] A_STATUS = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        prot_i = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [4:0]  fz_addr;
    logic        fz_rden;
    logic [15:0] fz_q;
    logic [15:0] mem [32];

    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    always #5 clk = ~clk;

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'(i * 40503) ^ 16'h5AA5;
    end
    assign fz_q = mem[fz_addr];

    fuse_rd_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .prot_i    (prot_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fz_addr   (fz_addr),
        .fz_rden   (fz_rden),
        .fz_q      (fz_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference: 0 off, 1 standby, 2 busy, 3 done
    int          m_ph = 0;
    int          m_cnt = 0;
    logic [4:0]  m_idx = 0;
    logic [4:0]  m_cap = 0;
    logic [15:0] m_data = 0;
    logic        m_prot = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_cap = 0; m_data = 0; m_prot = 0;
        end else begin
            bit wr, rd, clr;
            wr  = bus_wr && mod_en;
            rd  = wr && bus_addr == A_MODE && bus_wdata[1];
            clr = wr && bus_addr == A_MODE && bus_wdata[2];
            m_prot = prot_i;
            if (!mod_en) m_ph = 0;
            else if (m_ph == 0) m_ph = 1;
            else if (m_ph == 1) begin
                if (rd) begin m_ph = 2; m_cnt = 0; m_cap = m_idx; end
            end else if (m_ph == 2) begin
                if (m_cnt == 7) begin m_data = mem[m_cap]; m_ph = 3; end
                else m_cnt++;
            end else if (clr) m_ph = 1;
            if (wr && bus_addr == A_INDEX) m_idx = bus_wdata[4:0];
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            A_RDATA:  return {16'h0, m_data};
            A_INDEX:  return {27'h0, m_idx};
            A_STATUS: return {27'h0, m_ph == 3, m_prot, m_ph == 1, m_ph == 2, 1'b0};
            default:  return 32'h0;
        endcase
    endfunction

    function automatic string tag(input logic [7:0] a);
        case (a)
            A_RDATA:  return "R6 model";
            A_INDEX:  return "R2 model";
            A_STATUS: return "R5 model";
            default:  return "R4 model";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            #2;
            chk(tag(bus_addr), bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_read(input int i);
        logic [31:0] v;
        int n;
        n = 0;
        wr(A_INDEX, i);
        wr(A_MODE, 32'h2);
        for (int k = 0; k < 24; k++) begin
            peek(A_STATUS, v);
            if (v[1]) n++;
            if (v[4]) break;
            if (i == 7 && k == 2) begin
                wr(A_INDEX, 9);       // R8 index change mid-access
                wr(A_MODE, 32'h2);    // R8 start while busy
            end
        end
        if (i != 7) chk("R5 busy length", n, 8);
        peek(A_RDATA, v);
        chk("R6 data word", v, {16'h0, mem[i]});
        if (i == 7) chk("R8 start during busy", v, {16'h0, mem[7]});
        peek(A_STATUS, v);
        chk("R6 done flags", v, 32'h18);
        if (i == 7) begin
            wr(A_MODE, 32'h2);        // R8 start while done
            peek(A_STATUS, v);
            chk("R8 start during done", v, 32'h18);
        end
        repeat (3) peek(A_STATUS, v);
        chk("R7 done sticky", v, 32'h18);
        wr(A_MODE, 32'h4);
        peek(A_STATUS, v);
        chk("R7 clear to standby", v, 32'h0C);
    endtask

    task automatic summary();
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        peek(A_STATUS, v); chk("R1 status in reset", v, 0);
        peek(A_RDATA, v);  chk("R1 data in reset", v, 0);
        peek(A_INDEX, v);  chk("R1 index in reset", v, 0);
        @(negedge clk) rst_n = 1'b1;

        wr(A_INDEX, 5);
        wr(A_MODE, 32'h2);
        peek(A_STATUS, v); chk("R4 start ignored when off", v, 32'h8);
        peek(A_INDEX, v);  chk("R4 index write ignored when off", v, 0);
        peek(A_STATUS, v); chk("R9 protect mirrored", v[3], 1);

        @(negedge clk);
        bus_addr = A_STATUS; mod_en = 1'b1;
        #1 chk("R3 no standby before edge", bus_rdata, 32'h8);
        peek(A_STATUS, v); chk("R3 standby after one cycle", v, 32'hC);

        wr(A_INDEX, 32'hFFFF_FFE3);
        peek(A_INDEX, v); chk("R2 index masked", v, 32'h3);

        for (int i = 0; i < 32; i++) do_read(i);

        wr(A_MODE, 32'h1);
        peek(A_STATUS, v); chk("R10 program start no effect", v, 32'hC);
        for (int k = 0; k < 6; k++) begin
            peek(A_STATUS, v); chk("R10 program busy low", v[0], 0);
        end

        wr(A_INDEX, 4);
        wr(A_MODE, 32'h2);
        repeat (3) peek(A_STATUS, v);
        chk("R5 busy mid-access", v, 32'hA);
        @(negedge clk) mod_en = 1'b0;
        peek(A_STATUS, v); chk("R11 abort parks", v, 32'h8);
        peek(A_RDATA, v);  chk("R11 data kept", v, {16'h0, mem[31]});
        @(negedge clk) mod_en = 1'b1;
        peek(A_STATUS, v); chk("R11 standby without done", v, 32'hC);

        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual hung expected finish");
            summary();
        end
    end

endmodule